// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the receive side of a serial port that owns the shift clock. A programmable divider sets the half period of the clock it drives out on `sclk`. The block samples the incoming data line once per clock period and assembles 8-bit or 9-bit words, least significant bit first. A finished word goes into a holding buffer. The buffer raises a ready flag, an optional interrupt, and an overrun flag when the previous word has not been read.

There are two receive modes. A one-shot request brings in exactly one word, and its busy bit then clears itself. A level enable keeps words coming back to back for as long as it stays high. If both are set, the level enable wins: the one-shot busy bit is left alone, and words keep arriving. Whenever nothing requests a transfer, or the port is disabled, the clock sits at its selected idle level.

Top module: `sync_rx_master`

## Requirements
- R1: After reset, and whenever `port_en` is low or neither `cont_en` nor `single_busy` is set, `sclk` equals `clk_idle_high`. After reset `rx_done`, `overrun`, `single_busy` and `irq` are 0.
- R2: Each phase of `sclk` lasts L+1 `clk` cycles. L is `div_val` when `wide_div`=1, and only its low 8 bits when `wide_div`=0.
- R3: `sdata_in` is sampled at the `clk` edge where `sclk` returns to its idle level. The first sample is bit 0, and 8-bit words appear on `rx_data[7:0]` in that order.
- R4: With `nine_bit`=1 each word has 9 samples. The ninth goes to `rx_bit9` and the first eight go to `rx_data`. With `nine_bit`=0, `rx_bit9` is loaded as 0.
- R5: A one-cycle `single_go` pulse sets `single_busy`. After one word, `single_busy` clears when `cont_en` is low, and `sclk` stays idle.
- R6: While `cont_en`=1, words are received back to back, each one starting L+1 cycles after the previous one ends.
- R7: If `cont_en` and `single_busy` are both set, continuous mode governs. `single_busy` stays 1 after a word completes, and the next word starts.
- R8: `rx_done` goes to 1 on the edge that completes a word. A `rd_strobe` pulse clears it. `irq` is `rx_done` AND `irq_en`.
- R9: If a word completes while `rx_done` is 1 and no `rd_strobe` is present, `overrun` is set and `rx_data`/`rx_bit9` keep the earlier word.
- R10: `overrun` is cleared on the cycle after `cont_en` falls from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Port enable |
| cont_en | input | 1 | Continuous receive enable (level) |
| single_go | input | 1 | One-shot receive request (pulse) |
| nine_bit | input | 1 | 9-bit word mode |
| wide_div | input | 1 | Use all DIV_W divider bits |
| clk_idle_high | input | 1 | Idle level of `sclk` |
| irq_en | input | 1 | Interrupt enable |
| rd_strobe | input | 1 | Buffer read pulse, clears `rx_done` |
| sdata_in | input | 1 | Serial data line |
| div_val | input | DIV_W | Half-period divider value |
| sclk | output | 1 | Generated shift clock |
| single_busy | output | 1 | One-shot receive pending |
| rx_done | output | 1 | Word ready in buffer |
| overrun | output | 1 | Word lost while buffer full |
| irq | output | 1 | Receive interrupt |
| rx_bit9 | output | 1 | Ninth received bit |
| rx_data | output | DATA_W | Received data byte |

## Verification
The bench presents each data bit as soon as `sclk` leaves idle and holds it until `sclk` returns, so the bits are placed on the true sampling edge without counting cycles. `rx_done`, `rx_data`, `rx_bit9` and `overrun` update on the same edge that returns `sclk` to idle after the last bit, and they are read at the next falling `clk` edge. `single_busy` clearing and the `overrun` clear after `cont_en` falls each take one register stage and are checked one cycle later. Phase width is measured by counting cycles while `sclk` is active.

// File: rtl/sync_rx_master.sv
module sync_rx_master #(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              cont_en,
  input  logic              single_go,
  input  logic              nine_bit,
  input  logic              wide_div,
  input  logic              clk_idle_high,
  input  logic              irq_en,
  input  logic              rd_strobe,
  input  logic              sdata_in,
  input  logic [DIV_W-1:0]  div_val,
  output logic              sclk,
  output logic              single_busy,
  output logic              rx_done,
  output logic              overrun,
  output logic              irq,
  output logic              rx_bit9,
  output logic [DATA_W-1:0] rx_data
);
  localparam int HALF = DIV_W / 2;
  localparam int BW   = $clog2(DATA_W + 2);

  logic [DIV_W-1:0] div_cnt, lim;
  logic [BW-1:0]    bit_cnt;
  logic [DATA_W:0]  shreg, word;
  logic phase, active, tick, sample, last_bit, word_done, buf_held, cont_q, cont_fall;

  assign lim       = wide_div ? div_val : {{(DIV_W-HALF){1'b0}}, div_val[HALF-1:0]};
  assign active    = port_en & (cont_en | single_busy);
  assign tick      = active & (div_cnt == lim);
  assign sample    = tick & phase;
  assign last_bit  = bit_cnt == (nine_bit ? BW'(DATA_W) : BW'(DATA_W-1));
  assign word_done = sample & last_bit;
  assign word      = {sdata_in, shreg[DATA_W:1]};
  assign buf_held  = rx_done & ~rd_strobe;
  assign cont_fall = cont_q & ~cont_en;
  assign sclk      = phase ^ clk_idle_high;
  assign irq       = rx_done & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      phase   <= 1'b0;
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (!active) begin
      div_cnt <= '0;
      phase   <= 1'b0;
      bit_cnt <= '0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) phase <= ~phase;
      if (sample) begin
        shreg   <= word;
        bit_cnt <= word_done ? '0 : bit_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      single_busy <= 1'b0;
      cont_q      <= 1'b0;
      rx_done     <= 1'b0;
      overrun     <= 1'b0;
      rx_bit9     <= 1'b0;
      rx_data     <= '0;
    end else begin
      cont_q <= cont_en;
      if (!port_en)                     single_busy <= 1'b0;
      else if (single_go)               single_busy <= 1'b1;
      else if (word_done && !cont_en)   single_busy <= 1'b0;
      if (word_done && !buf_held) begin
        rx_done <= 1'b1;
        rx_data <= nine_bit ? word[DATA_W-1:0] : word[DATA_W:1];
        rx_bit9 <= nine_bit & word[DATA_W];
      end else if (rd_strobe) begin
        rx_done <= 1'b0;
      end
      if (cont_fall)                    overrun <= 1'b0;
      else if (word_done && buf_held)   overrun <= 1'b1;
    end
  end

  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (sclk == clk_idle_high));
  // R5
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !cont_en && !single_go && port_en) |=> !single_busy);
  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && rx_done && !rd_strobe && !cont_fall) |=> overrun);
  // R9
  keep_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && rx_done && !rd_strobe) |=> ($stable(rx_data) && $stable(rx_bit9)));
  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !word_done) |=> !rx_done);
  // R10
  cont_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cont_fall |=> !overrun);
endmodule

// File: tb/test_sync_rx_master.sv
module test_sync_rx_master;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic port_en = 0, cont_en = 0, single_go = 0, nine_bit = 0, wide_div = 0;
  logic clk_idle_high = 0, irq_en = 0, rd_strobe = 0, sdata_in = 0;
  logic [15:0] div_val = 16'd1;
  logic sclk, single_busy, rx_done, overrun, irq, rx_bit9;
  logic [7:0] rx_data;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_rx_master i_sync_rx_master (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .cont_en(cont_en),
    .single_go(single_go), .nine_bit(nine_bit), .wide_div(wide_div),
    .clk_idle_high(clk_idle_high), .irq_en(irq_en), .rd_strobe(rd_strobe),
    .sdata_in(sdata_in), .div_val(div_val), .sclk(sclk),
    .single_busy(single_busy), .rx_done(rx_done), .overrun(overrun),
    .irq(irq), .rx_bit9(rx_bit9), .rx_data(rx_data));

  function automatic int exp_half(input logic [15:0] d, input logic w);
    return (w ? int'(d) : int'(d[7:0])) + 1;
  endfunction
  function automatic logic exp_bit9(input logic [8:0] w, input logic nb);
    return nb & w[8];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_sclk(input logic lvl);
    while (sclk != lvl) @(negedge clk);
  endtask

  task automatic recv(input logic [8:0] w);
    for (int i = 0; i < (nine_bit ? 9 : 8); i++) begin
      wait_sclk(~clk_idle_high);
      sdata_in = w[i];
      wait_sclk(clk_idle_high);
    end
  endtask

  task automatic pulse_read;
    rd_strobe = 1; @(negedge clk); rd_strobe = 0;
  endtask

  task automatic pulse_go;
    single_go = 1; @(negedge clk); single_go = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [8:0] w1, w2;
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sclk", sclk, 0); chk("R1 rx_done", rx_done, 0);
    chk("R1 overrun", overrun, 0); chk("R1 single_busy", single_busy, 0);
    chk("R1 irq", irq, 0);
    port_en = 1;
    repeat (5) @(negedge clk);
    chk("R1 idle enabled no request", sclk, 0);

    // R2 narrow mode ignores high byte
    div_val = 16'hA503; wide_div = 0;
    pulse_go;
    wait_sclk(1); n = 0;
    while (sclk) begin n++; @(negedge clk); end
    chk("R2 half narrow", n, exp_half(div_val, 0));
    wait_sclk(0); wait_sclk(1); wait_sclk(0);
    port_en = 0; @(negedge clk); port_en = 1; @(negedge clk);
    chk("R1 port off idle", sclk, 0);
    // R2 wide mode
    div_val = 16'h0105; wide_div = 1;
    pulse_go;
    wait_sclk(1); n = 0;
    while (sclk) begin n++; @(negedge clk); end
    chk("R2 half wide", n, exp_half(div_val, 1));
    port_en = 0; @(negedge clk); port_en = 1; wide_div = 0;
    if (rx_done) pulse_read;

    // R3 R4 R5 R8 random single words
    for (int k = 0; k < 12; k++) begin
      w1 = 9'($urandom);
      nine_bit = 1'($urandom);
      irq_en = 1'($urandom);
      div_val = {8'($urandom), 8'($urandom % 4)};
      pulse_go;
      chk("R5 busy set", single_busy, 1);
      recv(w1);
      chk("R8 rx_done", rx_done, 1);
      chk("R3 data", rx_data, w1[7:0]);
      chk("R4 bit9", rx_bit9, exp_bit9(w1, nine_bit));
      chk("R8 irq", irq, irq_en);
      @(negedge clk);
      chk("R5 busy clear", single_busy, 0);
      repeat (10) begin
        if (sclk != clk_idle_high) chk("R5 idle after word", sclk, clk_idle_high);
        @(negedge clk);
      end
      pulse_read;
      chk("R8 read clears", rx_done, 0);
      chk("R8 irq low", irq, 0);
    end

    // R1 R3 idle-high polarity
    clk_idle_high = 1; nine_bit = 0; div_val = 16'd2;
    @(negedge clk);
    chk("R1 idle high", sclk, 1);
    w1 = 9'h0A5;
    pulse_go; recv(w1);
    chk("R3 data idle high", rx_data, 8'hA5);
    pulse_read;
    clk_idle_high = 0; @(negedge clk);

    // R6 continuous with reads
    div_val = 16'd2; cont_en = 1;
    for (int k = 0; k < 4; k++) begin
      w1 = 9'($urandom);
      recv(w1);
      chk("R6 cont data", rx_data, w1[7:0]);
      pulse_read;
    end
    chk("R6 no overrun", overrun, 0);

    // R9 overrun discards new word
    w1 = 9'h03C; w2 = 9'h0C3;
    recv(w1); recv(w2);
    chk("R9 overrun set", overrun, 1);
    chk("R9 old data kept", rx_data, 8'h3C);
    cont_en = 0; @(negedge clk);
    // R10
    chk("R10 overrun cleared", overrun, 0);
    pulse_read;

    // R7 both enables: continuous wins
    cont_en = 1; pulse_go;
    w1 = 9'h05A; recv(w1);
    chk("R7 data", rx_data, 8'h5A);
    @(negedge clk);
    chk("R7 busy kept", single_busy, 1);
    wait_sclk(1);
    chk("R7 next word starts", sclk, 1);
    port_en = 0; cont_en = 0; @(negedge clk);
    chk("R1 port off", sclk, 0);
    chk("R7 busy cleared by port off", single_busy, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule